// File: doc/BRIEF.md
# Processor Exception Entry and Return Sequencer

This block moves a processor into a general or TLB-refill exception and brings it back out on an exception-return instruction. The pipeline raises a request with a cause code and some qualifiers: refill, TLB-class, bus-error and delay-slot. It also supplies the faulting PC, virtual address and address-space identifier. The block then computes the handler address and records the return address and cause. For TLB-class faults it also saves the translation context. It then issues a one-cycle redirect to the fetch unit.

On a return strobe the block redirects fetch to the saved return address and leaves exception level. It also pulses a request to clear the load-linked reservation. A return found in a branch delay slot is refused and reported instead. A small status-write port lets the kernel set the boot-vector select, exception level, interrupt enable and user-mode bits.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The handler base is 0x8000_0000 when the boot-vector bit is 0, and 0xBFC0_0200 when it is 1.
- R2: A refill taken with exception level 0 uses offset 0x000. Every other accepted exception, including a refill taken with exception level 1, uses offset 0x180.
- R3: An exception accepted with exception level 0 loads the return address and the delay flag. The return address is the PC minus 4 with delay flag 1 when `exc_in_delay` is 1, and the PC with delay flag 0 otherwise.
- R4: An exception accepted with exception level 1 leaves the return address and the delay flag unchanged.
- R5: Every accepted exception sets exception level to 1 and loads the cause code and the coprocessor-number field. The cycle after, `kernel_mode` is 1 and `int_allowed` is 0.
- R6: Bad address, translation-high VPN2/ASID and context VPN2 load only when `exc_tlb_class` is 1 and `exc_bus_err` is 0. VPN2 is bits 31:13 of the address. In every other case these registers keep their value.
- R7: A request with cause code 0 (interrupt) is ignored when exception level is 1 or interrupt enable is 0. A request with cause code 23 (watch) is ignored when exception level is 1. An ignored request produces no redirect and changes no state.
- R8: A return outside a delay slot redirects to the saved return address, clears exception level and pulses `llbit_clr`.
- R9: A return with `eret_in_delay` set pulses `eret_err`, produces no redirect and leaves exception level unchanged.
- R10: `redir_valid` is 1 for exactly the one cycle after an accepted exception or return. An accepted exception in the same cycle as a return takes priority and the return is dropped.
- R11: After reset the boot-vector bit is 1, the other status bits are 0, and `redir_valid`, `eret_err` and `llbit_clr` are 0.
- R12: A status write updates the boot-vector, exception-level, interrupt-enable and user-mode bits only in a cycle with no accepted exception and no accepted return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req | input | 1 | Exception request |
| exc_code | input | 5 | Cause code of the request |
| exc_ce | input | 2 | Coprocessor number for unusable faults |
| exc_tlb_refill | input | 1 | Request is a TLB refill |
| exc_tlb_class | input | 1 | Request is a refill, invalid or modified fault |
| exc_bus_err | input | 1 | Request is a bus error |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_in_delay | input | 1 | Faulting instruction sits in a delay slot |
| exc_vaddr | input | 32 | Faulting virtual address |
| exc_asid | input | 8 | Current address-space identifier |
| eret_req | input | 1 | Exception-return strobe |
| eret_in_delay | input | 1 | The return sits in a delay slot |
| stat_we | input | 1 | Status write strobe |
| stat_bev | input | 1 | Write value, boot-vector select |
| stat_exl | input | 1 | Write value, exception level |
| stat_ie | input | 1 | Write value, interrupt enable |
| stat_um | input | 1 | Write value, user mode |
| redir_valid | output | 1 | Redirect strobe |
| redir_pc | output | 32 | Redirect target |
| kernel_mode | output | 1 | Processor runs in kernel mode |
| int_allowed | output | 1 | Interrupts may be taken |
| eret_err | output | 1 | Illegal return pulse |
| llbit_clr | output | 1 | Clear the load-linked reservation |
| epc_q | output | 32 | Saved return address |
| status_bev | output | 1 | Boot-vector select |
| status_exl | output | 1 | Exception level |
| status_ie | output | 1 | Interrupt enable |
| status_um | output | 1 | User mode |
| cause_bd | output | 1 | Fault was in a delay slot |
| cause_code | output | 5 | Last cause code |
| cause_ce | output | 2 | Last coprocessor number |
| badvaddr | output | 32 | Saved faulting address |
| entryhi_vpn2 | output | 19 | Saved VPN2 for translation reload |
| entryhi_asid | output | 8 | Saved address-space identifier |
| context_vpn2 | output | 19 | Saved VPN2 for the page-table walk |

## Verification
The hardest case to reach is a nested exception. A second fault must arrive while exception level is still 1, so it must keep the first return address and delay flag, and it must move a refill from offset 0x000 to 0x180. The stimulus gets there either by forcing exception level through the status port before the request, or by raising two faults in a row with no return between them. The bench's own model carries the saved return address across rows. A same-cycle fault and return is driven directly to show that the fault wins.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam logic [31:0] VEC_BASE_NORMAL = 32'h8000_0000;
  localparam logic [31:0] VEC_BASE_BOOT   = 32'hBFC0_0200;
  localparam logic [31:0] VEC_OFF_REFILL  = 32'h0000_0000;
  localparam logic [31:0] VEC_OFF_GENERAL = 32'h0000_0180;

  localparam int unsigned CODE_W = 5;
  localparam logic [CODE_W-1:0] CODE_INT   = 5'd0;
  localparam logic [CODE_W-1:0] CODE_WATCH = 5'd23;

  typedef struct packed {
    logic bev;
    logic exl;
    logic ie;
    logic um;
  } stat_t;
endpackage

// File: rtl/exc_accept.sv
module exc_accept
  import exc_pkg::*;
(
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              exl,
  input  logic              ie,
  input  logic              eret_req,
  input  logic              eret_in_delay,
  output logic              take,
  output logic              eret_ok,
  output logic              eret_bad
);
  logic is_int;
  logic is_watch;
  logic blocked;

  always_comb begin
    is_int   = (exc_code == CODE_INT);
    is_watch = (exc_code == CODE_WATCH);
    // interrupts need enable and level 0; watch needs level 0
    blocked  = (is_int && (exl || !ie)) || (is_watch && exl);
    take     = exc_req && !blocked;
    // an accepted exception always wins over a return
    eret_ok  = eret_req && !take && !eret_in_delay;
    eret_bad = eret_req && !take && eret_in_delay;
  end
endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              bev,
  input  logic              refill,
  input  logic              exl_before,
  output logic [ADDR_W-1:0] vector
);
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offset;

  always_comb begin
    base   = bev ? ADDR_W'(VEC_BASE_BOOT) : ADDR_W'(VEC_BASE_NORMAL);
    // the refill slot is used only from a first-level fault
    offset = (refill && !exl_before) ? ADDR_W'(VEC_OFF_REFILL)
                                     : ADDR_W'(VEC_OFF_GENERAL);
    vector = base + offset;
  end
endmodule

// File: rtl/exc_cp0_state.sv
module exc_cp0_state
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ASID_W   = 8,
  parameter int unsigned CE_W     = 2,
  parameter int unsigned VPN2_LSB = 13,
  localparam int unsigned VPN2_W  = ADDR_W - VPN2_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              eret_ok,
  input  logic              stat_we,
  input  stat_t             stat_wr,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [CE_W-1:0]   exc_ce,
  input  logic              exc_tlb_class,
  input  logic              exc_bus_err,
  input  logic [ADDR_W-1:0] exc_pc,
  input  logic              exc_in_delay,
  input  logic [ADDR_W-1:0] exc_vaddr,
  input  logic [ASID_W-1:0] exc_asid,
  output stat_t             stat_q,
  output logic [ADDR_W-1:0] epc_q,
  output logic              bd_q,
  output logic [CODE_W-1:0] code_q,
  output logic [CE_W-1:0]   ce_q,
  output logic [ADDR_W-1:0] bva_q,
  output logic [VPN2_W-1:0] ehi_vpn2_q,
  output logic [ASID_W-1:0] ehi_asid_q,
  output logic [VPN2_W-1:0] ctx_vpn2_q
);
  // clock enables
  logic stat_en;
  logic epc_en;
  logic cause_en;
  logic tlb_en;

  // next-state values
  stat_t             stat_d;
  logic [ADDR_W-1:0] epc_d;
  logic              bd_d;
  logic [VPN2_W-1:0] vpn2_d;

  always_comb begin
    stat_en  = take || eret_ok || stat_we;
    epc_en   = take && !stat_q.exl;
    cause_en = take;
    tlb_en   = take && exc_tlb_class && !exc_bus_err;

    stat_d = stat_q;
    if (take) begin
      stat_d.exl = 1'b1;
    end else if (eret_ok) begin
      stat_d.exl = 1'b0;
    end else if (stat_we) begin
      stat_d = stat_wr;
    end

    if (exc_in_delay) begin
      epc_d = exc_pc - ADDR_W'(4);
      bd_d  = 1'b1;
    end else begin
      epc_d = exc_pc;
      bd_d  = 1'b0;
    end

    vpn2_d = exc_vaddr[ADDR_W-1:VPN2_LSB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '{bev: 1'b1, exl: 1'b0, ie: 1'b0, um: 1'b0};
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epc_q <= '0;
      bd_q  <= 1'b0;
    end else if (epc_en) begin
      epc_q <= epc_d;
      bd_q  <= bd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ce_q   <= '0;
    end else if (cause_en) begin
      code_q <= exc_code;
      ce_q   <= exc_ce;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bva_q      <= '0;
      ehi_vpn2_q <= '0;
      ehi_asid_q <= '0;
      ctx_vpn2_q <= '0;
    end else if (tlb_en) begin
      bva_q      <= exc_vaddr;
      ehi_vpn2_q <= vpn2_d;
      ehi_asid_q <= exc_asid;
      ctx_vpn2_q <= vpn2_d;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned ASID_W   = 8,
  parameter int unsigned CE_W     = 2,
  parameter int unsigned VPN2_LSB = 13,
  localparam int unsigned VPN2_W  = ADDR_W - VPN2_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_req,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [CE_W-1:0]   exc_ce,
  input  logic              exc_tlb_refill,
  input  logic              exc_tlb_class,
  input  logic              exc_bus_err,
  input  logic [ADDR_W-1:0] exc_pc,
  input  logic              exc_in_delay,
  input  logic [ADDR_W-1:0] exc_vaddr,
  input  logic [ASID_W-1:0] exc_asid,
  input  logic              eret_req,
  input  logic              eret_in_delay,
  input  logic              stat_we,
  input  logic              stat_bev,
  input  logic              stat_exl,
  input  logic              stat_ie,
  input  logic              stat_um,
  output logic              redir_valid,
  output logic [ADDR_W-1:0] redir_pc,
  output logic              kernel_mode,
  output logic              int_allowed,
  output logic              eret_err,
  output logic              llbit_clr,
  output logic [ADDR_W-1:0] epc_q,
  output logic              status_bev,
  output logic              status_exl,
  output logic              status_ie,
  output logic              status_um,
  output logic              cause_bd,
  output logic [CODE_W-1:0] cause_code,
  output logic [CE_W-1:0]   cause_ce,
  output logic [ADDR_W-1:0] badvaddr,
  output logic [VPN2_W-1:0] entryhi_vpn2,
  output logic [ASID_W-1:0] entryhi_asid,
  output logic [VPN2_W-1:0] context_vpn2
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n;
  logic rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_ok     <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_ok     <= rst_meta_n;
    end
  end

  stat_t             stat_q;
  stat_t             stat_wr;
  logic              take;
  logic              eret_ok;
  logic              eret_bad;
  logic [ADDR_W-1:0] vector;

  assign stat_wr = '{bev: stat_bev, exl: stat_exl, ie: stat_ie, um: stat_um};

  exc_accept u_accept (
    .exc_req       (exc_req),
    .exc_code      (exc_code),
    .exl           (stat_q.exl),
    .ie            (stat_q.ie),
    .eret_req      (eret_req),
    .eret_in_delay (eret_in_delay),
    .take          (take),
    .eret_ok       (eret_ok),
    .eret_bad      (eret_bad)
  );

  exc_vector_sel #(.ADDR_W(ADDR_W)) u_vec (
    .bev        (stat_q.bev),
    .refill     (exc_tlb_refill),
    .exl_before (stat_q.exl),
    .vector     (vector)
  );

  exc_cp0_state #(
    .ADDR_W   (ADDR_W),
    .ASID_W   (ASID_W),
    .CE_W     (CE_W),
    .VPN2_LSB (VPN2_LSB)
  ) u_state (
    .clk           (clk),
    .rst_n         (rst_ok),
    .take          (take),
    .eret_ok       (eret_ok),
    .stat_we       (stat_we),
    .stat_wr       (stat_wr),
    .exc_code      (exc_code),
    .exc_ce        (exc_ce),
    .exc_tlb_class (exc_tlb_class),
    .exc_bus_err   (exc_bus_err),
    .exc_pc        (exc_pc),
    .exc_in_delay  (exc_in_delay),
    .exc_vaddr     (exc_vaddr),
    .exc_asid      (exc_asid),
    .stat_q        (stat_q),
    .epc_q         (epc_q),
    .bd_q          (cause_bd),
    .code_q        (cause_code),
    .ce_q          (cause_ce),
    .bva_q         (badvaddr),
    .ehi_vpn2_q    (entryhi_vpn2),
    .ehi_asid_q    (entryhi_asid),
    .ctx_vpn2_q    (context_vpn2)
  );

  // redirect and pulse outputs
  logic              redir_valid_d;
  logic [ADDR_W-1:0] redir_pc_d;
  logic              redir_pc_en;

  always_comb begin
    redir_valid_d = take || eret_ok;
    redir_pc_en   = redir_valid_d;
    redir_pc_d    = take ? vector : epc_q;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      redir_valid <= 1'b0;
      eret_err    <= 1'b0;
      llbit_clr   <= 1'b0;
    end else begin
      redir_valid <= redir_valid_d;
      eret_err    <= eret_bad;
      llbit_clr   <= eret_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      redir_pc <= '0;
    end else if (redir_pc_en) begin
      redir_pc <= redir_pc_d;
    end
  end

  assign status_bev  = stat_q.bev;
  assign status_exl  = stat_q.exl;
  assign status_ie   = stat_q.ie;
  assign status_um   = stat_q.um;
  assign kernel_mode = stat_q.exl || !stat_q.um;
  assign int_allowed = stat_q.ie && !stat_q.exl;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              exc_req,
  input logic [4:0]        exc_code,
  input logic              exc_bus_err,
  input logic              eret_req,
  input logic              take,
  input logic              eret_ok,
  input logic              eret_bad,
  input logic              status_exl,
  input logic              kernel_mode,
  input logic              int_allowed,
  input logic              redir_valid,
  input logic [ADDR_W-1:0] redir_pc,
  input logic [ADDR_W-1:0] epc_q,
  input logic              cause_bd,
  input logic [ADDR_W-1:0] badvaddr,
  input logic              eret_err,
  input logic              llbit_clr
);
  assert_vec_region_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    take |=> (redir_pc[31:28] == 4'h8) || (redir_pc[31:20] == 12'hBFC));

  assert_nested_hold_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    (take && status_exl) |=> ($stable(epc_q) && $stable(cause_bd)));

  assert_entry_kernel_R5: assert property (@(posedge clk) disable iff (!rst_ok)
    take |=> (status_exl && kernel_mode && !int_allowed));

  assert_tlb_hold_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (take && exc_bus_err) |=> $stable(badvaddr));

  assert_int_masked_R7: assert property (@(posedge clk) disable iff (!rst_ok)
    (exc_req && exc_code == 5'd0 && status_exl && !eret_req) |=> !redir_valid);

  assert_eret_return_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    eret_ok |=> (!status_exl && llbit_clr && redir_pc == $past(epc_q)));

  assert_eret_refused_R9: assert property (@(posedge clk) disable iff (!rst_ok)
    eret_bad |=> (eret_err && !redir_valid && status_exl == $past(status_exl)));

  assert_redir_set_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    (take || eret_ok) |=> redir_valid);

  assert_redir_clear_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !(take || eret_ok) |=> !redir_valid);
endmodule

bind exc_entry_ctrl exc_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_ok      (rst_ok),
  .exc_req     (exc_req),
  .exc_code    (exc_code),
  .exc_bus_err (exc_bus_err),
  .eret_req    (eret_req),
  .take        (take),
  .eret_ok     (eret_ok),
  .eret_bad    (eret_bad),
  .status_exl  (status_exl),
  .kernel_mode (kernel_mode),
  .int_allowed (int_allowed),
  .redir_valid (redir_valid),
  .redir_pc    (redir_pc),
  .epc_q       (epc_q),
  .cause_bd    (cause_bd),
  .badvaddr    (badvaddr),
  .eret_err    (eret_err),
  .llbit_clr   (llbit_clr)
);

// File: tb/tb_exc_entry_ctrl.sv
module tb_exc_entry_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        exc_req;
  logic [4:0]  exc_code;
  logic [1:0]  exc_ce;
  logic        exc_tlb_refill, exc_tlb_class, exc_bus_err, exc_in_delay;
  logic [31:0] exc_pc, exc_vaddr;
  logic [7:0]  exc_asid;
  logic        eret_req, eret_in_delay;
  logic        stat_we, stat_bev, stat_exl, stat_ie, stat_um;
  logic        redir_valid, kernel_mode, int_allowed, eret_err, llbit_clr;
  logic [31:0] redir_pc, epc_q, badvaddr;
  logic        status_bev, status_exl, status_ie, status_um, cause_bd;
  logic [4:0]  cause_code;
  logic [1:0]  cause_ce;
  logic [18:0] entryhi_vpn2, context_vpn2;
  logic [7:0]  entryhi_asid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  exc_entry_ctrl dut (.*);

  typedef struct packed {
    logic        bev;
    logic        exl0;
    logic        refill;
    logic        tlbc;
    logic        buserr;
    logic        delay;
    logic [4:0]  code;
    logic [31:0] pc;
    logic [31:0] va;
    logic [31:0] exp_pc;
  } vec_t;

  localparam vec_t TABLE [6] = '{
    '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd2, 32'h0040_1000, 32'h1234_5678, 32'h8000_0000},
    '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 5'd2, 32'h0040_2000, 32'h2000_4000, 32'h8000_0180},
    '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd8, 32'h0040_3008, 32'h5555_0000, 32'hBFC0_0380},
    '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 5'd3, 32'h0040_4000, 32'h7000_2000, 32'hBFC0_0200},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 5'd6, 32'h0040_5000, 32'h9999_9999, 32'h8000_0180},
    '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1, 32'h0040_6004, 32'hFFFF_E123, 32'h8000_0180}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exc_req = 0; exc_code = 0; exc_ce = 0; exc_tlb_refill = 0; exc_tlb_class = 0;
    exc_bus_err = 0; exc_in_delay = 0; exc_pc = 0; exc_vaddr = 0; exc_asid = 0;
    eret_req = 0; eret_in_delay = 0;
    stat_we = 0; stat_bev = 0; stat_exl = 0; stat_ie = 0; stat_um = 0;
  endtask

  task automatic set_status(input bit bev, input bit exl, input bit ie, input bit um);
    @(negedge clk);
    stat_we = 1; stat_bev = bev; stat_exl = exl; stat_ie = ie; stat_um = um;
    @(negedge clk);
    stat_we = 0;
  endtask

  // returns at the negedge after the capturing edge
  task automatic raise(input logic [4:0] code, input logic [1:0] ce, input bit refill,
                       input bit tlbc, input bit buserr, input bit delay,
                       input logic [31:0] pc, input logic [31:0] va, input logic [7:0] asid,
                       input bit with_eret);
    @(negedge clk);
    exc_req = 1; exc_code = code; exc_ce = ce; exc_tlb_refill = refill;
    exc_tlb_class = tlbc; exc_bus_err = buserr; exc_in_delay = delay;
    exc_pc = pc; exc_vaddr = va; exc_asid = asid; eret_req = with_eret;
    @(negedge clk);
    exc_req = 0; eret_req = 0;
  endtask

  task automatic do_eret(input bit in_delay);
    @(negedge clk);
    eret_req = 1; eret_in_delay = in_delay;
    @(negedge clk);
    eret_req = 0; eret_in_delay = 0;
  endtask

  logic [31:0] m_epc, m_bva;
  logic        m_bd;

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(status_bev == 1 && status_exl == 0 && status_ie == 0 && status_um == 0,
          "R11 status", {28'd0, status_bev, status_exl, status_ie, status_um}, 32'h8);
    check(!redir_valid && !eret_err && !llbit_clr, "R11 pulses",
          {29'd0, redir_valid, eret_err, llbit_clr}, 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    m_epc = 0; m_bd = 0; m_bva = 0;
    foreach (TABLE[i]) begin
      set_status(TABLE[i].bev, TABLE[i].exl0, 1'b0, 1'b1);
      raise(TABLE[i].code, 2'(i), TABLE[i].refill, TABLE[i].tlbc, TABLE[i].buserr,
            TABLE[i].delay, TABLE[i].pc, TABLE[i].va, 8'(8'h10 + i), 1'b0);
      // R1 R2 vector
      check(redir_valid && redir_pc == TABLE[i].exp_pc, "R1/R2 vector", redir_pc,
            TABLE[i].exp_pc);
      if (!TABLE[i].exl0) begin
        m_epc = TABLE[i].delay ? TABLE[i].pc - 32'd4 : TABLE[i].pc;
        m_bd  = TABLE[i].delay;
      end
      // R3 first-level save, R4 nested hold
      check(epc_q == m_epc && cause_bd == m_bd, TABLE[i].exl0 ? "R4 hold" : "R3 save",
            epc_q, m_epc);
      // R5 level, mode, cause
      check(status_exl && kernel_mode && !int_allowed && cause_code == TABLE[i].code
            && cause_ce == 2'(i), "R5 entry", {27'd0, cause_code}, {27'd0, TABLE[i].code});
      if (TABLE[i].tlbc && !TABLE[i].buserr) m_bva = TABLE[i].va;
      // R6 translation capture
      check(badvaddr == m_bva && entryhi_vpn2 == m_bva[31:13] && context_vpn2 == m_bva[31:13],
            "R6 tlb capture", badvaddr, m_bva);
      @(negedge clk);
      check(!redir_valid, "R10 one cycle", {31'd0, redir_valid}, 32'd0);
    end

    // R7 interrupt with level 1
    set_status(0, 1, 1, 0);
    raise(5'd0, 2'd0, 0, 0, 0, 0, 32'h0050_0000, 0, 0, 0);
    check(!redir_valid && cause_code == 5'd1, "R7 int at exl", {31'd0, redir_valid}, 0);
    // R7 interrupt with enable 0
    set_status(0, 0, 0, 0);
    raise(5'd0, 2'd0, 0, 0, 0, 0, 32'h0050_0000, 0, 0, 0);
    check(!redir_valid && !status_exl, "R7 int disabled", {31'd0, status_exl}, 0);
    // R7 interrupt enabled and level 0 is taken
    set_status(0, 0, 1, 0);
    raise(5'd0, 2'd0, 0, 0, 0, 0, 32'h0050_0000, 0, 0, 0);
    check(redir_valid && redir_pc == 32'h8000_0180, "R7 int taken", redir_pc, 32'h8000_0180);
    // R7 watch at level 1 ignored
    raise(5'd23, 2'd0, 0, 0, 0, 0, 32'h0060_0000, 0, 0, 0);
    check(!redir_valid && cause_code == 5'd0 && epc_q == 32'h0050_0000, "R7 watch",
          epc_q, 32'h0050_0000);

    // R8 return
    set_status(0, 0, 0, 1);
    raise(5'd8, 2'd0, 0, 0, 0, 0, 32'h0070_0000, 0, 0, 0);
    do_eret(0);
    check(redir_valid && redir_pc == 32'h0070_0000, "R8 target", redir_pc, 32'h0070_0000);
    check(llbit_clr && !status_exl && !kernel_mode, "R8 level",
          {30'd0, llbit_clr, status_exl}, 32'h2);

    // R9 refused return
    raise(5'd8, 2'd0, 0, 0, 0, 0, 32'h0071_0000, 0, 0, 0);
    do_eret(1);
    check(eret_err && !redir_valid && status_exl && !llbit_clr, "R9 refused",
          {29'd0, eret_err, redir_valid, status_exl}, 32'h5);

    // R10 exception beats return in same cycle (nested: level is 1)
    raise(5'd10, 2'd0, 0, 0, 0, 0, 32'h0072_0000, 0, 0, 1);
    check(redir_valid && redir_pc == 32'h8000_0180 && status_exl, "R10 priority",
          redir_pc, 32'h8000_0180);
    @(negedge clk);
    check(!redir_valid, "R10 pulse", {31'd0, redir_valid}, 0);

    // R12 status write, then write blocked by exception
    set_status(1, 0, 1, 1);
    check(status_bev && !status_exl && status_ie && status_um, "R12 write",
          {28'd0, status_bev, status_exl, status_ie, status_um}, 32'hB);
    @(negedge clk);
    exc_req = 1; exc_code = 5'd8; exc_pc = 32'h0080_0000;
    stat_we = 1; stat_bev = 0; stat_exl = 0; stat_ie = 0; stat_um = 0;
    @(negedge clk);
    exc_req = 0; stat_we = 0;
    check(status_bev && status_exl && status_ie && status_um && redir_pc == 32'hBFC0_0380,
          "R12 blocked", {28'd0, status_bev, status_exl, status_ie, status_um}, 32'hF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule